// File: doc/BRIEF.md
# Response FIFO Drain Engine

This engine pulls a response out of a device that exposes its outgoing data through a byte-wide register window. Each burst follows the same steps. The engine polls the device status byte until the device reports both that data is waiting and that the status is valid. It then fetches a 16-bit burst count as two single-byte reads and pops that many bytes from the device's data register. The number of bytes popped in one burst is also capped by how many bytes are still owed.

Each byte popped from the device goes out on a valid/ready byte stream. The engine keeps at most one byte in flight, so a stalled consumer also stalls the register bus.

A start pulse supplies the number of bytes wanted and a flag that picks one of two modes. In full-length mode the engine collects the whole amount. In header mode it stops after the first burst that brings the total to six bytes or more. When it finishes, the engine gives a one-cycle completion pulse with the byte count. A status wait that runs past its limit ends the transfer with a timeout flag and the last status byte seen.

Top module: `fifo_rsp_drain`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `timeout`, `bus_rd` and `out_valid` are all low.
- R2: The status byte is read at offset 0x18. No burst-count read and no data read is issued until the most recent status read returned bit 7 (valid) and bit 4 (data waiting) both set.
- R3: The engine may wait for status longer than `STAT_TMO` clock cycles without seeing both bits. In that case it ends the transfer: `done` and `timeout` are high in the same cycle, `err_status` holds the last status byte read, and `busy` falls.
- R4: The burst count is read as offset 0x19 (bits 7:0) immediately followed by offset 0x1A (bits 15:8). No other register is read between the two.
- R5: A zero burst count is fetched again, and successive low-byte fetches are at least `POLL_GAP` cycles apart. After `BURST_TMO` cycles of zero counts, the burst is taken as zero: no data byte is read, and the engine goes back to waiting for status.
- R6: Each burst pops exactly min(bytes still owed, burst count) bytes from offset 0x24 before the next status read. The only exception is the burst that ends the transfer.
- R7: With `full_len` low, the transfer ends after the first burst that brings the delivered total to 6 bytes or more, even if `req_len` is larger.
- R8: A transfer never delivers more than `req_len` bytes, and with `full_len` high it delivers exactly `req_len`. A `req_len` of zero completes with a count of 0 and no bus reads.
- R9: Bytes appear on `out_data` in the order the device FIFO supplies them. A held byte stays stable until accepted, and no data read is issued while `out_valid` is high.
- R10: `done` is a one-cycle pulse, raised only after the last byte has been accepted. `byte_count` equals the number of bytes delivered, and `busy` is low from then on.
- R11: A `start` pulse while `busy` is high has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| req_len | input | LEN_W | Bytes requested |
| full_len | input | 1 | 1: collect all bytes; 0: stop once 6 or more are collected |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Set with `done` when the status wait expired |
| err_status | output | 8 | Last status byte read before a timeout |
| byte_count | output | LEN_W | Bytes delivered in the current or last transfer |
| bus_addr | output | ADDR_W | Register offset for the read |
| bus_rd | output | 1 | Read strobe; data is returned one cycle later |
| bus_rdata | input | 8 | Read data from the device |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
The bench runs a behavioural device with a byte queue, a programmable status byte and a burst count that can be forced to zero for a given number of fetches. It targets these corner cases:
- A burst larger than the bytes still owed: a design without the min() over-reads and leaves the FIFO short.
- Header mode with bursts below and above six bytes: a design that checks the threshold per byte, or never, stops early or reads too much.
- A status byte with only one of the two bits set: a design that gates on only one of them reads data too early.
- Zero burst counts, with and without recovery: a design that does not go back to status waiting hangs, and one that polls too fast breaks the minimum gap.
- Two further cases: a stalled consumer, where a second read would overwrite the held byte, and a start pulse in the middle of a transfer, where a design that relatches it changes the count.

// File: rtl/fifo_drain_pkg.sv
package fifo_drain_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_STQ, S_STC, S_BLQ, S_BLC, S_BHQ, S_BHC,
    S_POLL, S_DRQ, S_DRC, S_FIN
  } drain_state_e;

  localparam logic [7:0] STAT_OFS = 8'h18;
  localparam logic [7:0] BLO_OFS  = 8'h19;
  localparam logic [7:0] BHI_OFS  = 8'h1A;
  localparam logic [7:0] FIFO_OFS = 8'h24;

  localparam int STS_VALID_BIT = 7;
  localparam int STS_AVAIL_BIT = 4;
  localparam int HDR_MIN       = 6;

endpackage

// File: rtl/drain_tick_timer.sv
module drain_tick_timer #(
  parameter int W = 34,
  parameter logic [W-1:0] LIMIT = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);

  logic [W-1:0] cnt_q;

  assign expired = (cnt_q >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en && !expired) cnt_q <= cnt_q + W'(1);
  end

  AST_TMR_SAT: assert property (@(posedge clk) disable iff (rst) cnt_q <= LIMIT); // R3

endmodule

// File: rtl/drain_out_reg.sv
module drain_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (rst) load |-> !out_valid); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

endmodule

// File: rtl/fifo_rsp_drain.sv
module fifo_rsp_drain
  import fifo_drain_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 12,
  parameter int TMO_W  = 34,
  parameter logic [TMO_W-1:0] STAT_TMO  = TMO_W'(64'd12_000_000_000),
  parameter logic [TMO_W-1:0] BURST_TMO = TMO_W'(64'd200_000_000),
  parameter logic [TMO_W-1:0] POLL_GAP  = TMO_W'(64'd1_000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              full_len,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [7:0]        err_status,
  output logic [LEN_W-1:0]  byte_count,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  input  logic [7:0]        bus_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready
);

  localparam int CW = (LEN_W > 16) ? LEN_W : 16;

  drain_state_e     state, nxt;
  logic [LEN_W-1:0] len_q, cnt_q, cnt_nx;
  logic             full_q, tmo_q;
  logic [CW-1:0]    left_q, rem_x, burst_x;
  logic [7:0]       blo_q;
  logic             stat_ok, stat_exp, burst_exp, poll_exp, last_all;
  logic             stat_clr, stat_en, burst_clr, burst_en, poll_clr, poll_en;

  assign stat_ok  = bus_rdata[STS_VALID_BIT] && bus_rdata[STS_AVAIL_BIT];
  assign cnt_nx   = cnt_q + LEN_W'(1);
  assign rem_x    = CW'(len_q) - CW'(cnt_q);
  assign burst_x  = CW'({bus_rdata, blo_q});
  assign last_all = (cnt_nx == len_q) || (!full_q && (cnt_nx >= LEN_W'(HDR_MIN)));

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (start) nxt = (req_len == '0) ? S_FIN : S_STQ;
      S_STQ:  nxt = S_STC;
      S_STC:  nxt = stat_ok ? S_BLQ : (stat_exp ? S_FIN : S_STQ);
      S_BLQ:  nxt = S_BLC;
      S_BLC:  nxt = S_BHQ;
      S_BHQ:  nxt = S_BHC;
      S_BHC:  nxt = (burst_x != '0) ? S_DRQ : (burst_exp ? S_STQ : S_POLL);
      S_POLL: if (poll_exp) nxt = S_BLQ;
      S_DRQ:  if (!out_valid) nxt = S_DRC;
      S_DRC:  nxt = (left_q == CW'(1)) ? (last_all ? S_FIN : S_STQ) : S_DRQ;
      S_FIN:  if (!out_valid) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign stat_clr  = (nxt == S_STQ) && (state != S_STC);
  assign stat_en   = (state == S_STQ) || (state == S_STC);
  assign burst_clr = (state == S_STC) && (nxt == S_BLQ);
  assign burst_en  = (state == S_BLQ) || (state == S_BLC) || (state == S_BHQ) ||
                     (state == S_BHC) || (state == S_POLL);
  assign poll_clr  = (state == S_BHC) && (nxt == S_POLL);
  assign poll_en   = (state == S_POLL);

  drain_tick_timer #(.W(TMO_W), .LIMIT(STAT_TMO)) u_stat_tmr (
    .clk(clk), .rst(rst), .clr(stat_clr), .en(stat_en), .expired(stat_exp));
  drain_tick_timer #(.W(TMO_W), .LIMIT(BURST_TMO)) u_burst_tmr (
    .clk(clk), .rst(rst), .clr(burst_clr), .en(burst_en), .expired(burst_exp));
  drain_tick_timer #(.W(TMO_W), .LIMIT(POLL_GAP)) u_poll_tmr (
    .clk(clk), .rst(rst), .clr(poll_clr), .en(poll_en), .expired(poll_exp));

  drain_out_reg #(.DW(8)) u_out (
    .clk(clk), .rst(rst), .load(state == S_DRC), .din(bus_rdata),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data));

  always_comb begin
    bus_rd   = 1'b0;
    bus_addr = '0;
    case (state)
      S_STQ: begin bus_rd = 1'b1; bus_addr = ADDR_W'(STAT_OFS); end
      S_BLQ: begin bus_rd = 1'b1; bus_addr = ADDR_W'(BLO_OFS);  end
      S_BHQ: begin bus_rd = 1'b1; bus_addr = ADDR_W'(BHI_OFS);  end
      S_DRQ: begin bus_rd = !out_valid; bus_addr = ADDR_W'(FIFO_OFS); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      len_q      <= '0;
      full_q     <= 1'b0;
      cnt_q      <= '0;
      left_q     <= '0;
      blo_q      <= '0;
      tmo_q      <= 1'b0;
      err_status <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      state   <= nxt;
      done    <= 1'b0;
      timeout <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          len_q  <= req_len;
          full_q <= full_len;
          cnt_q  <= '0;
          tmo_q  <= 1'b0;
          busy   <= 1'b1;
        end
        S_STC: if (!stat_ok && stat_exp) begin
          tmo_q      <= 1'b1;
          err_status <= bus_rdata;
        end
        S_BLC: blo_q <= bus_rdata;
        S_BHC: left_q <= (burst_x < rem_x) ? burst_x : rem_x;
        S_DRC: begin
          cnt_q  <= cnt_nx;
          left_q <= left_q - CW'(1);
        end
        S_FIN: if (!out_valid) begin
          done    <= 1'b1;
          timeout <= tmo_q;
          busy    <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign byte_count = cnt_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R10
  AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (rst) timeout |-> done); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) busy |-> (cnt_q <= len_q)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(len_q)); // R11

endmodule

// File: tb/tb_fifo_rsp_drain.sv
module tb_fifo_rsp_drain;

  localparam int STAT_TMO  = 300;
  localparam int BURST_TMO = 60;
  localparam int POLL_GAP  = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] req_len = '0;
  logic        full_len = 1'b0;
  logic        out_ready = 1'b1;
  logic [7:0]  bus_rdata = '0;
  logic        busy, done, timeout, bus_rd, out_valid;
  logic [7:0]  err_status, out_data;
  logic [15:0] byte_count;
  logic [11:0] bus_addr;

  always #5 clk = ~clk;

  fifo_rsp_drain #(
    .STAT_TMO(34'(STAT_TMO)), .BURST_TMO(34'(BURST_TMO)), .POLL_GAP(34'(POLL_GAP))
  ) dut (
    .clk(clk), .rst(rst), .start(start), .req_len(req_len), .full_len(full_len),
    .busy(busy), .done(done), .timeout(timeout), .err_status(err_status),
    .byte_count(byte_count), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready));

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural device
  logic [7:0] dev_stat = 8'h90;
  int  dev_burst = 8;
  int  zero_left = 0;
  logic [7:0] fifo[$];
  logic [7:0] expq[$];
  int  bval = 0;
  int  allowed = 0;
  bit  gate_ok = 0;
  bit  zero_pend = 0;
  bit  retreat_seen = 0;
  longint cyc = 0;
  longint last_blo_cyc = 0;
  logic [11:0] last_addr = '0;
  int  n_stat_rd = 0, n_blo_rd = 0, n_data_rd = 0, n_got = 0;
  bit  rdy_rand = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst && bus_rd) begin
      case (bus_addr)
        12'h018: begin
          chk(allowed == 0, "R6", "status read before burst consumed", allowed, 0);
          bus_rdata <= dev_stat;
          n_stat_rd++;
          gate_ok = dev_stat[7] && dev_stat[4];
          if (zero_pend) retreat_seen = 1;
          zero_pend = 0;
          allowed = 0;
        end
        12'h019: begin
          chk(gate_ok, "R2", "burst read without status gate", 0, 1);
          if (zero_pend)
            chk(cyc - last_blo_cyc >= POLL_GAP, "R5", "poll gap", cyc - last_blo_cyc, POLL_GAP);
          last_blo_cyc = cyc;
          n_blo_rd++;
          bval = (zero_left > 0) ? 0 : dev_burst;
          bus_rdata <= 8'(bval);
        end
        12'h01A: begin
          chk(last_addr == 12'h019, "R4", "high byte not after low byte", last_addr, 12'h019);
          bus_rdata <= 8'(bval >> 8);
          if (zero_left > 0) zero_left--;
          allowed = bval;
          zero_pend = (bval == 0);
        end
        12'h024: begin
          chk(gate_ok && allowed > 0, "R6", "data read beyond burst", allowed, 1);
          chk(!out_valid, "R9", "data read while byte held", out_valid, 0);
          if (allowed > 0) allowed--;
          n_data_rd++;
          if (fifo.size() > 0) bus_rdata <= fifo.pop_front();
          else bus_rdata <= 8'hEE;
        end
        default: chk(0, "R4", "unexpected address", bus_addr, 0);
      endcase
      last_addr = bus_addr;
    end
  end

  // consumer
  initial begin
    forever begin
      @(negedge clk);
      out_ready = rdy_rand ? 1'($urandom % 2) : 1'b1;
      if (!rst && out_valid && out_ready) begin
        n_got++;
        if (expq.size() > 0) begin
          chk(out_data == expq[0], "R9", "byte order", out_data, expq[0]);
          void'(expq.pop_front());
        end else chk(0, "R8", "extra byte delivered", out_data, 0);
      end
    end
  end

  task automatic prep(input int n, input int seed, input logic [7:0] st,
                      input int burst, input int zeros);
    fifo.delete(); expq.delete();
    for (int i = 0; i < n; i++) begin
      fifo.push_back(8'(seed + i * 13));
      expq.push_back(8'(seed + i * 13));
    end
    dev_stat = st; dev_burst = burst; zero_left = zeros;
    n_stat_rd = 0; n_blo_rd = 0; n_data_rd = 0; n_got = 0;
    allowed = 0; gate_ok = 0; zero_pend = 0; retreat_seen = 0;
  endtask

  task automatic run(input int len, input bit full, output int cnt,
                     output bit tmo, output int cycles);
    @(negedge clk);
    start = 1'b1; req_len = 16'(len); full_len = full;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 4000) begin
      @(negedge clk);
      cycles++;
    end
    chk(done, "R10", "done never seen", 0, 1);
    cnt = byte_count; tmo = timeout;
    @(negedge clk);
    chk(!done && !busy, "R10", "done not single pulse / busy", {done, busy}, 0);
  endtask

  initial begin
    #(10 * 180000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cnt, cyc_n;
    bit tmo;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !timeout && !bus_rd && !out_valid, "R1", "reset state",
        {busy, done, timeout, bus_rd, out_valid}, 0);

    // full mode, burst larger than tail
    prep(23, 1, 8'h90, 8, 0);
    run(20, 1, cnt, tmo, cyc_n);
    chk(cnt == 20 && n_got == 20, "R8", "full length count", cnt, 20);
    chk(n_stat_rd == 3, "R6", "status reads for bursts 8,8,4", n_stat_rd, 3);
    chk(fifo.size() == 3, "R6", "bytes left in device", fifo.size(), 3);

    // header mode, bursts of 4
    prep(23, 40, 8'h90, 4, 0);
    run(20, 0, cnt, tmo, cyc_n);
    chk(cnt == 8 && n_got == 8, "R7", "header stop after 8", cnt, 8);
    chk(n_stat_rd == 2, "R7", "two bursts", n_stat_rd, 2);

    // header mode, burst of 10
    prep(23, 77, 8'h90, 10, 0);
    run(20, 0, cnt, tmo, cyc_n);
    chk(cnt == 10 && n_data_rd == 10, "R7", "header stop after one burst", cnt, 10);

    // header mode, short length
    prep(10, 5, 8'h90, 8, 0);
    run(3, 0, cnt, tmo, cyc_n);
    chk(cnt == 3 && n_data_rd == 3, "R8", "short header length", cnt, 3);

    // zero length
    prep(4, 9, 8'h90, 8, 0);
    run(0, 1, cnt, tmo, cyc_n);
    chk(cnt == 0 && n_stat_rd == 0 && n_data_rd == 0, "R8", "zero length no reads",
        n_stat_rd + n_data_rd, 0);

    // delayed status: data-only, then valid-only, then both
    prep(8, 20, 8'h10, 16, 0);
    fork
      run(5, 1, cnt, tmo, cyc_n);
      begin
        repeat (30) @(negedge clk);
        chk(n_blo_rd == 0 && n_data_rd == 0, "R2", "reads with avail only", n_blo_rd, 0);
        dev_stat = 8'h80;
        repeat (30) @(negedge clk);
        chk(n_blo_rd == 0 && n_data_rd == 0, "R2", "reads with valid only", n_blo_rd, 0);
        dev_stat = 8'h90;
      end
    join
    chk(cnt == 5 && !tmo, "R2", "completes after gate opens", cnt, 5);

    // zero burst retries then recovery
    prep(8, 60, 8'h90, 6, 3);
    run(6, 1, cnt, tmo, cyc_n);
    chk(cnt == 6 && n_blo_rd == 4, "R5", "three zero polls then burst", n_blo_rd, 4);

    // zero burst past burst timeout
    prep(8, 90, 8'h90, 4, 1000000);
    fork
      run(4, 1, cnt, tmo, cyc_n);
      begin
        repeat (250) @(negedge clk);
        chk(retreat_seen, "R5", "returned to status wait", retreat_seen, 1);
        chk(n_data_rd == 0 && busy, "R5", "no data on zero burst", n_data_rd, 0);
        zero_left = 0;
      end
    join
    chk(cnt == 4 && !tmo, "R5", "recovers after zero bursts", cnt, 4);

    // backpressure
    prep(30, 3, 8'h90, 7, 0);
    rdy_rand = 1;
    run(30, 1, cnt, tmo, cyc_n);
    rdy_rand = 0;
    chk(cnt == 30 && n_got == 30 && expq.size() == 0, "R9", "stream under stall", n_got, 30);

    // start while busy
    prep(12, 111, 8'h90, 3, 0);
    fork
      run(10, 1, cnt, tmo, cyc_n);
      begin
        repeat (12) @(negedge clk);
        start = 1'b1; req_len = 16'd3;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(cnt == 10 && n_got == 10, "R11", "mid-run start ignored", cnt, 10);

    // status timeout
    prep(8, 7, 8'h80, 8, 0);
    run(5, 1, cnt, tmo, cyc_n);
    chk(tmo, "R3", "timeout flagged", tmo, 1);
    chk(err_status == 8'h80, "R3", "last status", err_status, 8'h80);
    chk(cnt == 0 && n_data_rd == 0, "R3", "no bytes on timeout", cnt, 0);
    chk(cyc_n >= STAT_TMO && cyc_n <= STAT_TMO + 12, "R3", "timeout latency", cyc_n, STAT_TMO);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule